// File: doc/BRIEF.md
# Credit-Gated Transmit Packet Segmenter

The segmenter takes packets from a word-wide source and cuts them into wide transmit beats for a look-aside protocol core. Each beat has eight 64-bit word slots. The source offers one 64-bit word per transfer under a valid/ready handshake. With the first word of a packet it also gives the packet length in bytes and a channel number. The block places the words into slots and marks the start and end of each packet. It emits a finished beat on the next cycle that the credit gate allows.

Output validity is governed only by a credit input. The valid strobe repeats the credit input exactly a fixed number of cycles later, whatever data is or is not available. In a valid cycle the block presents one of two things:
- a finished data beat, if one is waiting;
- otherwise an idle beat with every idle flag set.

The first beat of a packet keeps its top slot free for the burst control word the core inserts there. That beat therefore carries at most seven data words. Later beats of the same packet use all eight slots. The last beat reports how many bytes are valid in its final word through a compact 4-bit code. A packet that ends part-way through a beat leaves the rest of that beat empty. The next packet always starts in a fresh beat.

Top module: `tx_segmenter`

## Requirements
- R1: While reset is held, and on the first cycle after it, out_valid, in_ready, out_idle, out_sop and out_eop are all zero.
- R2: out_valid in cycle n equals the credit input in cycle n-CRED_LAT (default 4), whatever the data input does.
- R3: in_ready is high only in a cycle where out_valid is high and no finished data beat is waiting. In particular it stays low while credit has been low for CRED_LAT cycles, and no word is taken then.
- R4: A packet's first beat has out_sop = 8'h80, meaning only the slot-7 flag is set. Its data words fill slot 6 (out_data[447:384]) downward to slot 0 (out_data[63:0]), in arrival order.
- R5: In a start beat the packet's channel appears in the slot-7 channel field, out_chan[63:56]. In every data beat all other channel fields are zero, and every channel field is zero in beats without a start flag.
- R6: Words after the first seven of a packet go into following beats with out_sop = 0. Each such beat is filled from slot 7 (out_data[511:448]) down to slot 0.
- R7: out_eop is 4'b0000 in a data beat that does not end its packet. In the beat holding the packet's last word it is {1'b1, L[2:0]}, where L is the packet length in bytes: 4'b1000 means 8 valid bytes in the last word and 4'b1001 means 1 valid byte.
- R8: In a valid cycle with no finished data beat waiting, the output is an idle beat: out_idle = 8'hFF, out_sop = 0 and out_eop = 0. Data beats carry out_idle = 0.
- R9: Slots after a packet's last word in its final beat are zero. The next packet starts in a new beat at slot 6, with the start flag in slot 7.
- R10: When out_valid is low, out_idle, out_sop and out_eop are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| credit | input | 1 | Credit grant; reappears as out_valid CRED_LAT cycles later |
| in_valid | input | 1 | Source word available |
| in_ready | output | 1 | Block takes the word at this clock edge |
| in_data | input | WORD_W (64) | Source data word |
| in_len | input | LEN_W (14) | Packet length in bytes (1 or more), sampled with the packet's first word |
| in_chan | input | CHAN_W (8) | Channel number, sampled with the packet's first word |
| out_valid | output | 1 | Beat valid |
| out_data | output | NUM_SLOTS*WORD_W (512) | Beat data, slot s at bits [s*64 +: 64] |
| out_sop | output | NUM_SLOTS (8) | Per-slot start flags |
| out_chan | output | NUM_SLOTS*CHAN_W (64) | Per-slot channel fields, slot s at bits [s*8 +: 8] |
| out_idle | output | NUM_SLOTS (8) | Per-slot idle flags |
| out_eop | output | 4 | End-of-packet code |

## Verification
Packets of several lengths are used, and each exposes a different slicing fault:
- A 49-byte packet and a 1-byte packet end inside the start beat. They show whether slot 7 is skipped and whether the end code is raised in the same beat as the start flag.
- A 120-byte packet and a 200-byte packet cross into full continuation beats. They separate the 7-slot start-beat fill from the 8-slot fill of later beats, and the 8-byte end code from the partial codes.
- A 20-byte packet followed at once by a 9-byte packet shows whether unused slots are zeroed and whether each packet restarts in a fresh beat.
- Runs with constant, toggling and absent credit, set against a credit history the bench keeps itself, separate a valid strobe that follows the delayed credit from one that follows data availability.

// File: rtl/tx_seg_pkg.sv
package tx_seg_pkg;
    localparam int EOP_W      = 4;
    localparam int WORD_BYTES = 8;

    // End code: top bit marks the last beat, low bits give the valid bytes (0 means 8)
    function automatic logic [EOP_W-1:0] mk_eop(input logic [2:0] lo_bytes);
        return {1'b1, lo_bytes};
    endfunction
endpackage

// File: rtl/tx_seg_credit_dly.sv
module tx_seg_credit_dly #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic credit_in,
    output logic credit_out
);
    logic [LAT-1:0] sr_d, sr_q;

    generate
        if (LAT == 1) begin : g_single
            always_comb sr_d = credit_in;
        end else begin : g_chain
            always_comb sr_d = {sr_q[LAT-2:0], credit_in};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign credit_out = sr_q[LAT-1];
endmodule

// File: rtl/tx_seg_beat_build.sv
module tx_seg_beat_build
    import tx_seg_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int WORD_W    = 64,
    parameter int CHAN_W    = 8,
    parameter int LEN_W     = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        take,
    input  logic [WORD_W-1:0]           in_data,
    input  logic [LEN_W-1:0]            in_len,
    input  logic [CHAN_W-1:0]           in_chan,
    input  logic                        emit,
    output logic                        full,
    output logic [NUM_SLOTS*WORD_W-1:0] beat_data,
    output logic                        beat_sop,
    output logic [CHAN_W-1:0]           beat_chan,
    output logic [EOP_W-1:0]            beat_eop
);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][WORD_W-1:0] data;
        logic [SLOT_W-1:0]                slot;
        logic                             busy;
        logic [LEN_W-1:0]                 rem;
        logic [CHAN_W-1:0]                chan;
        logic                             sop;
        logic [EOP_W-1:0]                 eop;
        logic                             full;
    } st_t;

    st_t              st_d, st_q;
    logic [LEN_W-1:0]  cur_rem;
    logic [SLOT_W-1:0] cur_slot;

    always_comb begin
        st_d     = st_q;
        cur_rem  = st_q.busy ? st_q.rem  : in_len;
        cur_slot = st_q.busy ? st_q.slot : SLOT_W'(NUM_SLOTS - 2);
        if (emit) begin
            st_d.data = '0;
            st_d.full = 1'b0;
            st_d.sop  = 1'b0;
            st_d.eop  = '0;
        end
        if (take) begin
            if (!st_q.busy) begin
                st_d.chan = in_chan;
                st_d.sop  = 1'b1;
            end
            st_d.data[cur_slot] = in_data;
            if (cur_rem <= LEN_W'(WORD_BYTES)) begin
                st_d.eop  = mk_eop(cur_rem[2:0]);
                st_d.full = 1'b1;
                st_d.busy = 1'b0;
                st_d.rem  = '0;
            end else begin
                st_d.busy = 1'b1;
                st_d.rem  = cur_rem - LEN_W'(WORD_BYTES);
                if (cur_slot == '0) begin
                    st_d.full = 1'b1;
                    st_d.slot = SLOT_W'(NUM_SLOTS - 1);
                end else begin
                    st_d.slot = cur_slot - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full      = st_q.full;
    assign beat_data = st_q.data;
    assign beat_sop  = st_q.sop;
    assign beat_chan = st_q.chan;
    assign beat_eop  = st_q.eop;
endmodule

// File: rtl/tx_segmenter.sv
module tx_segmenter
    import tx_seg_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int WORD_W    = 64,
    parameter int CHAN_W    = 8,
    parameter int LEN_W     = 14,
    parameter int CRED_LAT  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        credit,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [WORD_W-1:0]           in_data,
    input  logic [LEN_W-1:0]            in_len,
    input  logic [CHAN_W-1:0]           in_chan,
    output logic                        out_valid,
    output logic [NUM_SLOTS*WORD_W-1:0] out_data,
    output logic [NUM_SLOTS-1:0]        out_sop,
    output logic [NUM_SLOTS*CHAN_W-1:0] out_chan,
    output logic [NUM_SLOTS-1:0]        out_idle,
    output logic [EOP_W-1:0]            out_eop
);
    logic                        cred_ok;
    logic                        full;
    logic                        take;
    logic                        emit;
    logic [NUM_SLOTS*WORD_W-1:0] beat_data;
    logic                        beat_sop;
    logic [CHAN_W-1:0]           beat_chan;
    logic [EOP_W-1:0]            beat_eop;

    tx_seg_credit_dly #(.LAT(CRED_LAT)) u_cdly (
        .clk        (clk),
        .rst_n      (rst_n),
        .credit_in  (credit),
        .credit_out (cred_ok)
    );

    assign in_ready = cred_ok && !full;
    assign take     = in_valid && in_ready;
    assign emit     = cred_ok && full;

    tx_seg_beat_build #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORD_W    (WORD_W),
        .CHAN_W    (CHAN_W),
        .LEN_W     (LEN_W)
    ) u_build (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .in_data   (in_data),
        .in_len    (in_len),
        .in_chan   (in_chan),
        .emit      (emit),
        .full      (full),
        .beat_data (beat_data),
        .beat_sop  (beat_sop),
        .beat_chan (beat_chan),
        .beat_eop  (beat_eop)
    );

    always_comb begin
        out_valid = cred_ok;
        out_data  = '0;
        out_sop   = '0;
        out_chan  = '0;
        out_idle  = '0;
        out_eop   = '0;
        if (cred_ok) begin
            if (full) begin
                out_data = beat_data;
                out_eop  = beat_eop;
                if (beat_sop) begin
                    out_sop[NUM_SLOTS-1]                   = 1'b1;
                    out_chan[NUM_SLOTS*CHAN_W-1 -: CHAN_W] = beat_chan;
                end
            end else begin
                out_idle = '1;
            end
        end
    end
endmodule

// File: rtl/tx_segmenter_chk.sv
module tx_segmenter_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int CHAN_W    = 8,
    parameter int CRED_LAT  = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        credit,
    input logic                        in_ready,
    input logic                        out_valid,
    input logic [NUM_SLOTS-1:0]        out_sop,
    input logic [NUM_SLOTS*CHAN_W-1:0] out_chan,
    input logic [NUM_SLOTS-1:0]        out_idle,
    input logic [3:0]                  out_eop
);
    logic [CRED_LAT:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[CRED_LAT-1:0], credit};
    end

    AST_VALID_TRACKS_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist[CRED_LAT-1]); // R2
    AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_valid); // R3
    AST_READY_HELD_BY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idle == '0) |-> !in_ready); // R3
    AST_SOP_TOP_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_sop[NUM_SLOTS-2:0] == '0); // R4
    AST_CHAN_NEEDS_SOP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sop == '0) |-> (out_chan == '0)); // R5
    AST_EOP_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_eop != '0) |-> out_eop[3]); // R7
    AST_IDLE_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idle != '0) |-> (&out_idle && out_sop == '0 && out_eop == '0)); // R8
    AST_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_idle == '0 && out_sop == '0 && out_eop == '0)); // R10
endmodule

bind tx_segmenter tx_segmenter_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .CHAN_W    (CHAN_W),
    .CRED_LAT  (CRED_LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .credit    (credit),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_chan  (out_chan),
    .out_idle  (out_idle),
    .out_eop   (out_eop)
);

// File: tb/tx_segmenter_bench.sv
module tx_segmenter_bench;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         credit = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [63:0]  in_data = '0;
    logic [13:0]  in_len = '0;
    logic [7:0]   in_chan = '0;
    logic         out_valid;
    logic [511:0] out_data;
    logic [7:0]   out_sop;
    logic [63:0]  out_chan;
    logic [7:0]   out_idle;
    logic [3:0]   out_eop;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    tx_segmenter u_tx_segmenter (
        .clk(clk), .rst_n(rst_n), .credit(credit), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .in_len(in_len), .in_chan(in_chan),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
        .out_chan(out_chan), .out_idle(out_idle), .out_eop(out_eop)
    );

    // captured data beats
    logic [511:0] cap_data [64];
    logic [7:0]   cap_sop  [64];
    logic [63:0]  cap_chan [64];
    logic [3:0]   cap_eop  [64];
    int cap_n = 0;
    int idle_n = 0;
    int idle_bad = 0, quiet_bad = 0, ready_bad = 0, valid_bad = 0;
    logic [LAT-1:0] hist = '0;

    always @(posedge clk) begin
        #1;
        hist = {hist[LAT-2:0], credit};
        if (rst_n) begin
            if (out_valid !== hist[LAT-1]) valid_bad++;
            if (in_ready && !out_valid) ready_bad++;
            if (!out_valid && (out_idle != 0 || out_sop != 0 || out_eop != 0)) quiet_bad++;
            if (out_valid && out_idle != 0) begin
                idle_n++;
                if (out_idle != 8'hFF || out_sop != 0 || out_eop != 0) idle_bad++;
            end
            if (out_valid && out_idle == 0 && cap_n < 64) begin
                cap_data[cap_n] = out_data;
                cap_sop[cap_n]  = out_sop;
                cap_chan[cap_n] = out_chan;
                cap_eop[cap_n]  = out_eop;
                cap_n++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [511:0] act, input logic [511:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_pkt(input int len, input logic [7:0] chan, input logic [31:0] base);
        int nw;
        nw = (len + 7) / 8;
        for (int k = 0; k < nw; k++) begin
            in_valid = 1'b1;
            in_data  = {base, 32'(k)};
            in_len   = 14'(len);
            in_chan  = chan;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic wait_beats(input int n);
        for (int i = 0; i < 3000 && cap_n < n; i++) @(negedge clk);
    endtask

    function automatic int beats_of(input int len);
        int nw;
        nw = (len + 7) / 8;
        return (nw <= 7) ? 1 : 1 + (nw - 7 + 7) / 8;
    endfunction

    task automatic check_pkt(input int first, input int len, input logic [7:0] chan, input logic [31:0] base);
        int nw, nb, idx;
        logic [511:0] ed;
        logic [3:0] ee;
        logic [13:0] l14;
        nw = (len + 7) / 8;
        nb = beats_of(len);
        l14 = 14'(len);
        chk(cap_n >= first + nb, "R6 beat count", 512'(cap_n - first), 512'(nb));
        for (int b = 0; b < nb; b++) begin
            ed = '0;
            for (int s = 0; s < 8; s++) begin
                if (b == 0) idx = (s <= 6) ? 6 - s : -1;
                else        idx = 7 + (b - 1) * 8 + (7 - s);
                if (idx >= 0 && idx < nw) ed[s*64 +: 64] = {base, 32'(idx)};
            end
            ee = (b == nb - 1) ? {1'b1, l14[2:0]} : 4'b0000;
            chk(cap_data[first+b] == ed, (b == 0) ? "R4 R9 start beat data" : "R6 R9 cont beat data",
                cap_data[first+b], ed);
            chk(cap_sop[first+b] == ((b == 0) ? 8'h80 : 8'h00), "R4 R6 sop flags",
                512'(cap_sop[first+b]), 512'((b == 0) ? 8'h80 : 8'h00));
            chk(cap_chan[first+b] == ((b == 0) ? {chan, 56'h0} : 64'h0), "R5 channel fields",
                512'(cap_chan[first+b]), 512'((b == 0) ? {chan, 56'h0} : 64'h0));
            chk(cap_eop[first+b] == ee, "R7 eop code", 512'(cap_eop[first+b]), 512'(ee));
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 0 && out_idle == 0 && out_sop == 0 && out_eop == 0,
            "R1 reset outputs", 512'({out_valid, in_ready, out_idle, out_sop, out_eop}), 512'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && in_ready == 0 && out_idle == 0, "R1 after release",
            512'({out_valid, in_ready, out_idle}), 512'(0));
    endtask

    task automatic t_idle;
        int i0;
        credit = 1'b1;
        repeat (LAT + 3) @(negedge clk);
        i0 = idle_n;
        repeat (4) @(negedge clk);
        chk(idle_n - i0 == 4 && out_idle == 8'hFF && out_sop == 0 && out_eop == 0, "R8 idle beats",
            512'(idle_n - i0), 512'(4));
        chk(in_ready == 1, "R3 ready with credit and no beat", 512'(in_ready), 512'(1));
    endtask

    task automatic t_pkt(input int len, input logic [7:0] chan, input logic [31:0] base);
        int f;
        f = cap_n;
        send_pkt(len, chan, base);
        wait_beats(f + beats_of(len));
        check_pkt(f, len, chan, base);
    endtask

    task automatic t_back_to_back;
        int f;
        f = cap_n;
        send_pkt(20, 8'h11, 32'hB0B0_0001);
        send_pkt(9, 8'h22, 32'hB0B0_0002);
        wait_beats(f + 2);
        check_pkt(f, 20, 8'h11, 32'hB0B0_0001);     // R9 unused slots zero
        check_pkt(f + 1, 9, 8'h22, 32'hB0B0_0002);  // R9 fresh beat
    endtask

    task automatic t_toggle_credit;
        int f;
        f = cap_n;
        fork
            send_pkt(120, 8'h09, 32'hC0DE_0009);
            begin
                for (int i = 0; i < 60; i++) begin
                    credit = (i % 3) != 1;
                    @(negedge clk);
                end
                credit = 1'b1;
            end
        join
        wait_beats(f + 2);
        check_pkt(f, 120, 8'h09, 32'hC0DE_0009);
    endtask

    task automatic t_no_credit;
        int f;
        credit = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        chk(out_valid == 0 && out_idle == 0 && out_sop == 0 && out_eop == 0, "R10 quiet without credit",
            512'({out_valid, out_idle, out_sop, out_eop}), 512'(0));
        f = cap_n;
        fork
            send_pkt(1, 8'h33, 32'hDD00_0033);
            begin
                repeat (8) @(negedge clk);
                chk(in_ready == 0 && cap_n == f, "R3 nothing taken without credit",
                    512'({in_ready, 8'(cap_n - f)}), 512'(0));
                credit = 1'b1;
            end
        join
        wait_beats(f + 1);
        check_pkt(f, 1, 8'h33, 32'hDD00_0033);
    endtask

    initial begin
        t_reset();
        t_idle();
        t_pkt(120, 8'h05, 32'hA000_0120);   // R4 R6 R7 8-byte end
        t_pkt(49, 8'h03, 32'hA000_0049);    // R7 1-byte end in start beat
        t_pkt(1, 8'h7E, 32'hA000_0001);     // R9 single word
        t_pkt(200, 8'hF0, 32'hA000_0200);   // R6 several continuation beats
        t_back_to_back();
        t_toggle_credit();
        t_no_credit();
        repeat (10) @(negedge clk);
        chk(valid_bad == 0, "R2 valid tracks delayed credit", 512'(valid_bad), 512'(0));
        chk(ready_bad == 0, "R3 ready only when valid", 512'(ready_bad), 512'(0));
        chk(idle_bad == 0, "R8 idle beat form", 512'(idle_bad), 512'(0));
        chk(quiet_bad == 0, "R10 outputs quiet when invalid", 512'(quiet_bad), 512'(0));
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_500_000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule